// File: doc/BRIEF.md
# Keyed Indexed Configuration Register Port

This block holds the configuration space of a multi-function I/O controller. Software reaches it through two byte-wide locations on a small bus: an index location and a data location. The bus has a one-bit address, a write strobe, a read strobe and write and read data. The space stays locked after reset. It opens only when a two-byte key is written to the index location. A single lock byte written there closes it again.

When the space is open, the index selects one register, and the data location reads or writes that register. A few registers are global. The rest are banked: a device-select register picks one of the logical devices, and banked indexes then reach that device's bank. Each device bank holds an enable bit, a 16-bit base address, an interrupt number and a DMA channel, and all of them drive output ports continuously. The keyboard/mouse device has an extra interrupt number for the mouse. The default device numbering is: 0 floppy, 1 and 2 unused, 3 parallel, 4 and 5 serial, 6 clock, 7 keyboard/mouse, 8 general I/O.

Read data is returned as a response. `bus_rvalid` pulses for one cycle, in the cycle after the read strobe, and `bus_rdata` is valid while it is high. The block accepts one access in every cycle and never applies back-pressure, so the bus has no ready signal. A read strobe and a write strobe in the same cycle are allowed. In that case the read returns the state from before the write.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the space is locked (`cfg_open`=0), every bank output is 0, `aux_irq` is 0 and `bus_rvalid` is 0.
- R2: The space opens only when two consecutive index-location writes carry 0x51 and then 0x23. Data-location writes are not counted in this sequence. Any other index write that follows a 0x51, including a second 0x51, returns key detection to idle.
- R3: While the space is open, writing 0xBB to the index location locks it and leaves the index register unchanged. Any other index write while open loads the index register.
- R4: While the space is locked, data-location writes have no effect, and reads of either location return 0xFF.
- R5: A read strobe produces `bus_rvalid`=1 one cycle later. Reading the index location while the space is open returns the current index.
- R6: Index 0x07 is the device-select register, a full byte that reads back as written. If the selected device number is NDEV or higher, banked writes are dropped and banked reads return 0x00.
- R7: Index 0x30 bit 0 is the enable bit of the selected device and drives `dev_active[d]`. Reads return only that bit.
- R8: Index 0x60 and index 0x61 hold the high byte and the low byte of the base address, which appears on `dev_base[16d+15:16d]`. Index 0x70 holds the interrupt number (`dev_irq`) and index 0x74 holds the DMA channel (`dev_dma`), each a byte at `[8d+7:8d]`.
- R9: Index 0x72 exists only in the bank of device AUX_DEV (default 7), where it drives `aux_irq`. In any other bank, writes to 0x72 are dropped and reads return 0x00.
- R10: A data write with bit 0 set to index 0x02 clears every bank and the device select. The space stays open and the index register is unchanged. A write to 0x02 with bit 0 clear does nothing.
- R11: Writes to indexes that are not implemented are dropped, and reads of them return 0x00. Index 0x02 always reads 0x00.
- R12: A banked write changes only the bank of the currently selected device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read response data, valid when bus_rvalid=1 |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| cfg_open | output | 1 | Configuration space is unlocked |
| dev_active | output | NDEV | Per-device enable bits |
| dev_base | output | 16*NDEV | Per-device base addresses |
| dev_irq | output | 8*NDEV | Per-device interrupt numbers |
| dev_dma | output | 8*NDEV | Per-device DMA channels |
| aux_irq | output | 8 | Second interrupt number of device AUX_DEV |

## Verification
The bank contents drive output ports continuously. A wrong bank write, or a missed soft reset, therefore shows on `dev_*` or `aux_irq` in the cycle after the faulty write. It does not have to wait for a later read. Errors in the key detector or the lock logic show immediately on `cfg_open`, and on the 0xFF read pattern of the next read. A wrong device select or a wrong index register shows only through the side effects of the following access, or through read data one cycle after a read strobe. For this reason the bench reads back after each group of writes, and it compares every port in every cycle.

// File: rtl/cfg_keyed_pkg.sv
package cfg_keyed_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] LOCK_BYTE  = 8'hBB;

  localparam logic [7:0] IX_SRST    = 8'h02;
  localparam logic [7:0] IX_DEVSEL  = 8'h07;
  localparam logic [7:0] IX_BANKLO  = 8'h30;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_H  = 8'h60;
  localparam logic [7:0] IX_BASE_L  = 8'h61;
  localparam logic [7:0] IX_IRQ     = 8'h70;
  localparam logic [7:0] IX_AUXIRQ  = 8'h72;
  localparam logic [7:0] IX_DMA     = 8'h74;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_keyed_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KS_LOCKED: if (wdata == KEY_FIRST) st_d = KS_HALF;
        KS_HALF:   st_d = (wdata == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (wdata == LOCK_BYTE) st_d = KS_LOCKED;
        default:   st_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign open = (st_q == KS_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(idx_wr && wdata == KEY_SECOND)); // R2
  AST_LOCK_BYTE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open && idx_wr && wdata == LOCK_BYTE) |=> !open); // R3
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_keyed_pkg::*;
#(
  parameter bit HAS_AUX = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        we,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] base,
  output logic [7:0]  irq,
  output logic [7:0]  dma,
  output logic [7:0]  aux,
  output logic [7:0]  rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      irq    <= '0;
      dma    <= '0;
    end else if (clr) begin
      active <= 1'b0;
      base   <= '0;
      irq    <= '0;
      dma    <= '0;
    end else if (we) begin
      case (idx)
        IX_ACT:    active     <= wdata[0];
        IX_BASE_H: base[15:8] <= wdata;
        IX_BASE_L: base[7:0]  <= wdata;
        IX_IRQ:    irq        <= wdata;
        IX_DMA:    dma        <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_AUX) begin : g_aux
      logic [7:0] aux_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          aux_q <= '0;
        else if (clr)                        aux_q <= '0;
        else if (we && idx == IX_AUXIRQ)     aux_q <= wdata;
      end
      assign aux = aux_q;
    end else begin : g_no_aux
      assign aux = '0;
    end
  endgenerate

  always_comb begin
    case (idx)
      IX_ACT:    rd_val = {7'd0, active};
      IX_BASE_H: rd_val = base[15:8];
      IX_BASE_L: rd_val = base[7:0];
      IX_IRQ:    rd_val = irq;
      IX_DMA:    rd_val = dma;
      IX_AUXIRQ: rd_val = aux;
      default:   rd_val = 8'h00;
    endcase
  end

  AST_BANK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!active && base == 16'd0 && irq == 8'd0 && dma == 8'd0 && aux == 8'd0)); // R10
  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> ($stable(active) && $stable(base) && $stable(irq) && $stable(dma) && $stable(aux))); // R12
endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
  import cfg_keyed_pkg::*;
#(
  parameter int NDEV    = 9,
  parameter int AUX_DEV = 7
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 bus_rvalid,
  output logic                 cfg_open,
  output logic [NDEV-1:0]      dev_active,
  output logic [NDEV*16-1:0]   dev_base,
  output logic [NDEV*8-1:0]    dev_irq,
  output logic [NDEV*8-1:0]    dev_dma,
  output logic [7:0]           aux_irq
);
  localparam int BASE_W = 16;
  localparam int BYTE_W = 8;

  logic       idx_wr, dat_wr;
  logic [7:0] idx_q, sel_q;
  logic       soft_rst, banked_wr;
  logic [NDEV-1:0] bank_we;
  logic [7:0] bank_rd [NDEV];
  logic [7:0] bank_aux [NDEV];
  logic [7:0] rd_bank, rd_mux;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr && bus_addr;

  cfg_key_fsm u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (bus_wdata),
    .open   (cfg_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (cfg_open && idx_wr && bus_wdata != LOCK_BYTE) idx_q <= bus_wdata;
  end

  assign soft_rst  = cfg_open && dat_wr && idx_q == IX_SRST && bus_wdata[0];
  assign banked_wr = cfg_open && dat_wr && idx_q >= IX_BANKLO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      sel_q <= '0;
    else if (soft_rst)                               sel_q <= '0;
    else if (cfg_open && dat_wr && idx_q == IX_DEVSEL) sel_q <= bus_wdata;
  end

  generate
    for (genvar d = 0; d < NDEV; d++) begin : g_bank
      assign bank_we[d] = banked_wr && (sel_q == 8'(d));
      cfg_dev_bank #(.HAS_AUX(d == AUX_DEV)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .we     (bank_we[d]),
        .idx    (idx_q),
        .wdata  (bus_wdata),
        .active (dev_active[d]),
        .base   (dev_base[d*BASE_W +: BASE_W]),
        .irq    (dev_irq[d*BYTE_W +: BYTE_W]),
        .dma    (dev_dma[d*BYTE_W +: BYTE_W]),
        .aux    (bank_aux[d]),
        .rd_val (bank_rd[d])
      );
    end
  endgenerate

  always_comb begin
    aux_irq = '0;
    for (int d = 0; d < NDEV; d++) aux_irq = aux_irq | bank_aux[d];
  end

  always_comb begin
    rd_bank = 8'h00;
    for (int d = 0; d < NDEV; d++)
      if (sel_q == 8'(d)) rd_bank = bank_rd[d];
  end

  always_comb begin
    if (!cfg_open)                 rd_mux = 8'hFF;
    else if (!bus_addr)            rd_mux = idx_q;
    else if (idx_q == IX_DEVSEL)   rd_mux = sel_q;
    else if (idx_q >= IX_BANKLO)   rd_mux = rd_bank;
    else                           rd_mux = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_open) |=> bus_rdata == 8'hFF); // R4
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open) |=> ($stable(dev_base) && $stable(dev_active) && $stable(sel_q))); // R4
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R5
  AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R12
  AST_SRST_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_open && sel_q == 8'd0)); // R10
endmodule

// File: tb/tb_cfg_keyed_port.sv
`timescale 1ns/1ps
module tb_cfg_keyed_port;
  localparam int NDEV = 9;
  localparam int AUXD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid, cfg_open;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV*8-1:0] dev_irq, dev_dma;
  logic [7:0] aux_irq;

  always #2.5 clk = ~clk;

  cfg_keyed_port #(.NDEV(NDEV), .AUX_DEV(AUXD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cfg_open(cfg_open), .dev_active(dev_active), .dev_base(dev_base),
    .dev_irq(dev_irq), .dev_dma(dev_dma), .aux_irq(aux_irq)
  );

  // behavioural reference
  int m_st;  // 0 locked, 1 half key, 2 open
  int m_idx, m_sel, m_aux;
  int m_act[NDEV], m_base[NDEV], m_irq[NDEV], m_dma[NDEV];
  int m_rvalid, m_rdata;

  int n_vec = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  task automatic m_clear();
    m_sel = 0; m_aux = 0;
    for (int d = 0; d < NDEV; d++) begin
      m_act[d] = 0; m_base[d] = 0; m_irq[d] = 0; m_dma[d] = 0;
    end
  endtask

  function automatic int m_read(input bit a);
    if (m_st != 2) return 255;
    if (!a) return m_idx;
    if (m_idx == 7) return m_sel;
    if (m_idx < 'h30 || m_sel >= NDEV) return 0;
    case (m_idx)
      'h30: return m_act[m_sel];
      'h60: return m_base[m_sel] >> 8;
      'h61: return m_base[m_sel] & 255;
      'h70: return m_irq[m_sel];
      'h74: return m_dma[m_sel];
      'h72: return (m_sel == AUXD) ? m_aux : 0;
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    int w;
    w = bus_wdata;
    m_rvalid = bus_rd;
    if (bus_rd) m_rdata = m_read(bus_addr);
    if (bus_wr && !bus_addr) begin
      if (m_st == 0) m_st = (w == 'h51) ? 1 : 0;
      else if (m_st == 1) m_st = (w == 'h23) ? 2 : 0;
      else if (w == 'hBB) m_st = 0;
      else m_idx = w;
    end else if (bus_wr && bus_addr && m_st == 2) begin
      if (m_idx == 2) begin
        if (w % 2 == 1) m_clear();
      end else if (m_idx == 7) m_sel = w;
      else if (m_idx >= 'h30 && m_sel < NDEV) begin
        case (m_idx)
          'h30: m_act[m_sel] = w % 2;
          'h60: m_base[m_sel] = (w << 8) | (m_base[m_sel] & 255);
          'h61: m_base[m_sel] = (m_base[m_sel] & 'hFF00) | w;
          'h70: m_irq[m_sel] = w;
          'h74: m_dma[m_sel] = w;
          'h72: if (m_sel == AUXD) m_aux = w;
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int d = 0; d < NDEV; d++) begin
      chk(tag, $sformatf("dev_active[%0d]", d), dev_active[d], m_act[d]);
      chk(tag, $sformatf("dev_base[%0d]", d), dev_base[d*16 +: 16], m_base[d]);
      chk(tag, $sformatf("dev_irq[%0d]", d), dev_irq[d*8 +: 8], m_irq[d]);
      chk(tag, $sformatf("dev_dma[%0d]", d), dev_dma[d*8 +: 8], m_dma[d]);
    end
    chk(tag, "aux_irq", aux_irq, m_aux);
    chk(tag, "cfg_open", cfg_open, (m_st == 2) ? 1 : 0);
    chk(tag, "bus_rvalid", bus_rvalid, m_rvalid);
    if (m_rvalid) chk(tag, "bus_rdata", bus_rdata, m_rdata);
  endtask

  task automatic cycle();
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare();
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input bit a, input int d);
    bus_addr = a; bus_wr = 1; bus_wdata = 8'(d);
    cycle();
  endtask

  task automatic rd(input bit a, input int exp, input string req);
    bus_addr = a; bus_rd = 1;
    cycle();
    chk(req, "explicit read", bus_rdata, exp);
  endtask

  task automatic reg_wr(input int ix, input int d);
    wr(0, ix); wr(1, d);
  endtask

  task automatic reg_rd(input int ix, input int exp, input string req);
    wr(0, ix); rd(1, exp, req);
  endtask

  initial begin
    m_st = 0; m_idx = 0; m_rvalid = 0; m_rdata = 0;
    m_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1"; cycle();
    chk("R1", "cfg_open after reset", cfg_open, 0);
    chk("R1", "dev_active after reset", dev_active, 0);
    // R4 locked behaviour
    tag = "R4";
    rd(0, 'hFF, "R4"); rd(1, 'hFF, "R4");
    wr(1, 'h55); wr(1, 'h12);
    chk("R4", "base unchanged while locked", dev_base, 0);
    // R2 bad keys
    tag = "R2";
    wr(0, 'h51); wr(0, 'h51); wr(0, 'h23);
    chk("R2", "double first key stays locked", cfg_open, 0);
    wr(0, 'h51); wr(0, 'h00); wr(0, 'h23);
    chk("R2", "broken key stays locked", cfg_open, 0);
    wr(0, 'h51); wr(1, 'h00); wr(0, 'h23);
    chk("R2", "data write does not break key", cfg_open, 1);
    // R5 index readback
    tag = "R5";
    wr(0, 'h44); rd(0, 'h44, "R5");
    // R7 R8 device 3
    tag = "R8";
    reg_wr('h07, 3); reg_rd('h07, 3, "R6");
    reg_wr('h30, 'hFF); reg_rd('h30, 1, "R7");
    chk("R7", "dev_active[3]", dev_active[3], 1);
    reg_wr('h60, 'h03); reg_wr('h61, 'h78); reg_wr('h70, 7); reg_wr('h74, 3);
    chk("R8", "dev_base[3]", dev_base[3*16 +: 16], 'h0378);
    reg_rd('h61, 'h78, "R8"); reg_rd('h74, 3, "R8");
    // R12 independence
    tag = "R12";
    reg_wr('h07, 4); reg_wr('h60, 'h03); reg_wr('h61, 'hF8); reg_wr('h70, 4);
    chk("R12", "dev_base[3] untouched", dev_base[3*16 +: 16], 'h0378);
    chk("R12", "dev_irq[4]", dev_irq[4*8 +: 8], 4);
    // R9 aux irq
    tag = "R9";
    reg_wr('h72, 5); reg_rd('h72, 0, "R9");
    chk("R9", "aux_irq untouched by dev4", aux_irq, 0);
    reg_wr('h07, 7); reg_wr('h72, 'h0C); reg_rd('h72, 'h0C, "R9");
    chk("R9", "aux_irq", aux_irq, 'h0C);
    // R6 out-of-range select
    tag = "R6";
    reg_wr('h07, 12); reg_wr('h60, 'hAA); reg_wr('h30, 1); reg_rd('h60, 0, "R6");
    reg_rd('h07, 12, "R6");
    // R11 unimplemented
    tag = "R11";
    reg_wr('h07, 3); reg_wr('h40, 'h99); reg_rd('h40, 0, "R11");
    reg_wr('h15, 'h99); reg_rd('h15, 0, "R11"); reg_rd('h02, 0, "R11");
    reg_rd('h30, 1, "R11");
    // R3 lock and relock
    tag = "R3";
    wr(0, 'h61); wr(0, 'hBB);
    chk("R3", "locked after lock byte", cfg_open, 0);
    rd(1, 'hFF, "R4"); wr(1, 'h00);
    wr(0, 'h51); wr(0, 'h23);
    rd(0, 'h61, "R3"); rd(1, 'h78, "R3");
    // R10 soft reset
    tag = "R10";
    reg_wr('h02, 'h00);
    chk("R10", "no reset on bit0 clear", dev_active[3], 1);
    wr(0, 'h02); wr(1, 'h01);
    chk("R10", "banks cleared", dev_base, 0);
    chk("R10", "aux cleared", aux_irq, 0);
    chk("R10", "still open", cfg_open, 1);
    rd(0, 'h02, "R10");
    reg_rd('h07, 0, "R10");
    repeat (3) cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule